// File: doc/BRIEF.md
# Little-endian byte-lane load/store adapter

This block connects the memory stage of a small in-order pipeline to a 32-bit wide, word-addressed RAM that has one write enable per byte. It takes the instruction's major opcode, a 32-bit byte address and the register value to store. From these it produces the RAM word address, the write word, the per-byte enables and the read and write strobes. A sub-word store puts its byte on all four lanes and enables only the one lane that is addressed. A byte load picks its lane out of the returned word. Byte order is little-endian.

The RAM reads synchronously, so its data arrives one cycle after the request. The block keeps the lane offset and the load kind of the request in a register for that cycle. It then presents the formatted result to the register-file write path. Only a region of 2^SPAN_LOG2 bytes starting at address zero is backed by memory (1 MB by default). Accesses above that region reach no RAM cell, so an address just past the top never reaches low memory.

Top module: `lsu_bytelane`

## Requirements
- R1: For any access that reaches the RAM, `ram_word_addr` equals byte-address bits [SPAN_LOG2-1:2], so the word address is the byte address divided by four.
- R2: A word store (opcode 6'b101011) at a backed address asserts `ram_wr`, drives `acc_wdata` unchanged onto `ram_wdata` and enables all four lanes (`ram_lane_en` = 4'b1111). Address bits [1:0] are ignored.
- R3: A byte store (opcode 6'b101000) at a backed address asserts `ram_wr` and drives `acc_wdata[7:0]` onto all four byte lanes of `ram_wdata`. It enables only lane `acc_addr[1:0]`, where lane k is bits [8k+7:8k] and offset 0 is the least significant lane.
- R4: A word load (opcode 6'b100011) at a backed address asserts `ram_rd`. One cycle later `ld_data` equals the whole returned word. Address bits [1:0] are ignored.
- R5: A signed byte load (opcode 6'b100000) returns, one cycle later, lane `acc_addr[1:0]` of the returned word, sign-extended to 32 bits.
- R6: An unsigned byte load (opcode 6'b100100) returns, one cycle later, the same selected lane, zero-extended to 32 bits.
- R7: An access at a byte address of 2^SPAN_LOG2 or above asserts neither `ram_wr` nor `ram_rd` and enables no lane. A load there returns zero. Memory at the low addresses is left unchanged, so there is no wrap-around.
- R8: Any opcode other than the five above asserts neither strobe and enables no lane. `ld_data` is zero in the following cycle.
- R9: While `rst_n` is low, and in the first cycle after it, `ld_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_op | input | 6 | Major opcode of the instruction in the memory stage |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 32 | Register value to store |
| ram_word_addr | output | SPAN_LOG2-2 | RAM word address |
| ram_wdata | output | 32 | RAM write word |
| ram_lane_en | output | 4 | Per-byte write enables, bit k for lane k |
| ram_wr | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_rdata | input | 32 | RAM read word, valid the cycle after `ram_rd` |
| ld_data | output | 32 | Formatted load result |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and SPAN_LOG2 = 20, which gives a backed region of 1 MB. It uses a sparse memory model, so the top word at 0x000FFFFC and the first unbacked address 0x00100000 can both be reached directly. With these values the test can write at the top of the region and then confirm that the write is kept. It can also store just past the boundary and read word zero back to show that no aliasing occurred. Random traffic is concentrated in a small window of low addresses, so byte and word accesses overlap often enough to check lane placement against a byte-level shadow memory.

// File: rtl/lsu_bytelane.sv
module lsu_bytelane #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 20,
  localparam int WORD_AW  = SPAN_LOG2 - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [5:0]         acc_op,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [31:0]        acc_wdata,
  output logic [WORD_AW-1:0] ram_word_addr,
  output logic [31:0]        ram_wdata,
  output logic [3:0]         ram_lane_en,
  output logic               ram_wr,
  output logic               ram_rd,
  input  logic [31:0]        ram_rdata,
  output logic [31:0]        ld_data
);
  localparam logic [5:0] OP_LB  = 6'b100000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_LBU = 6'b100100;
  localparam logic [5:0] OP_SB  = 6'b101000;
  localparam logic [5:0] OP_SW  = 6'b101011;

  typedef enum logic [1:0] {LD_NONE, LD_WORD, LD_BYTE_S, LD_BYTE_U} ld_kind_e;

  logic     in_span, is_load, is_store;
  ld_kind_e kind_d, kind_q;
  logic [1:0] lane_q;
  logic [7:0] lane_byte;

  assign in_span  = (acc_addr[ADDR_W-1:SPAN_LOG2] == '0);
  assign is_store = (acc_op == OP_SW) || (acc_op == OP_SB);
  assign is_load  = (acc_op == OP_LW) || (acc_op == OP_LB) || (acc_op == OP_LBU);

  assign ram_word_addr = acc_addr[SPAN_LOG2-1:2];
  assign ram_wr        = is_store && in_span;
  assign ram_rd        = is_load && in_span;
  assign ram_wdata     = (acc_op == OP_SB) ? {4{acc_wdata[7:0]}} : acc_wdata;

  always_comb begin
    ram_lane_en = 4'b0000;
    if (ram_wr)
      ram_lane_en = (acc_op == OP_SB) ? (4'b0001 << acc_addr[1:0]) : 4'b1111;
  end

  always_comb begin
    unique case (acc_op)
      OP_LW:   kind_d = LD_WORD;
      OP_LB:   kind_d = LD_BYTE_S;
      OP_LBU:  kind_d = LD_BYTE_U;
      default: kind_d = LD_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= LD_NONE;
      lane_q <= 2'b00;
    end else begin
      kind_q <= ram_rd ? kind_d : LD_NONE;
      lane_q <= acc_addr[1:0];
    end
  end

  assign lane_byte = ram_rdata[8*lane_q +: 8];

  always_comb begin
    unique case (kind_q)
      LD_WORD:   ld_data = ram_rdata;
      LD_BYTE_S: ld_data = {{24{lane_byte[7]}}, lane_byte};
      LD_BYTE_U: ld_data = {24'h0, lane_byte};
      default:   ld_data = 32'h0;
    endcase
  end
endmodule

// File: rtl/lsu_bytelane_chk.sv
module lsu_bytelane_chk #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [31:0]       ram_wdata,
  input logic [3:0]        ram_lane_en,
  input logic              ram_wr,
  input logic              ram_rd,
  input logic [31:0]       ld_data
);
  AST_WR_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr || ram_rd) |-> (acc_addr[ADDR_W-1:SPAN_LOG2] == '0)); // R7
  AST_NO_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_wr |-> (ram_lane_en == 4'b0000)); // R8
  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> ($countones(ram_lane_en) == 4 || $countones(ram_lane_en) == 1)); // R3
  AST_SB_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr && $countones(ram_lane_en) == 1) |->
      (ram_wdata[31:24] == ram_wdata[7:0] && ram_wdata[23:16] == ram_wdata[7:0]
       && ram_wdata[15:8] == ram_wdata[7:0])); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_wr && ram_rd)); // R8
  AST_ZERO_AFTER_NOLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rd |=> (ld_data == 32'h0)); // R7
endmodule

bind lsu_bytelane lsu_bytelane_chk #(.ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .ram_wdata(ram_wdata),
  .ram_lane_en(ram_lane_en), .ram_wr(ram_wr), .ram_rd(ram_rd), .ld_data(ld_data)
);

// File: tb/lsu_bytelane_tb.sv
`timescale 1ns/1ps
module lsu_bytelane_tb;
  localparam logic [5:0] LB = 6'b100000, LW = 6'b100011, LBU = 6'b100100;
  localparam logic [5:0] SB = 6'b101000, SW = 6'b101011, ADDI = 6'b001000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] acc_op = ADDI;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic [17:0] ram_word_addr;
  logic [31:0] ram_wdata, ram_rdata = '0, ld_data;
  logic [3:0] ram_lane_en;
  logic ram_wr, ram_rd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsu_bytelane u_dut (
    .clk(clk), .rst_n(rst_n), .acc_op(acc_op), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .ram_word_addr(ram_word_addr), .ram_wdata(ram_wdata), .ram_lane_en(ram_lane_en),
    .ram_wr(ram_wr), .ram_rd(ram_rd), .ram_rdata(ram_rdata), .ld_data(ld_data)
  );

  logic [31:0] ram_mem [bit [17:0]];
  always @(posedge clk) begin
    if (ram_wr) begin
      logic [31:0] w;
      w = ram_mem.exists(ram_word_addr) ? ram_mem[ram_word_addr] : 32'h0;
      for (int k = 0; k < 4; k++) if (ram_lane_en[k]) w[8*k +: 8] = ram_wdata[8*k +: 8];
      ram_mem[ram_word_addr] = w;
    end
    if (ram_rd) ram_rdata <= ram_mem.exists(ram_word_addr) ? ram_mem[ram_word_addr] : 32'h0;
  end

  logic [7:0] shadow [int unsigned];

  function automatic logic [7:0] sh_byte(int unsigned a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  function automatic logic [31:0] exp_load(logic [5:0] op, logic [31:0] a);
    logic [31:0] base = {a[31:2], 2'b00};
    logic [7:0] b = sh_byte(a);
    if (a >= 32'h0010_0000) return 32'h0;
    case (op)
      LW:  return {sh_byte(base+3), sh_byte(base+2), sh_byte(base+1), sh_byte(base)};
      LB:  return {{24{b[7]}}, b};
      LBU: return {24'h0, b};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_op(logic [5:0] op, logic [31:0] a, logic [31:0] d);
    bit backed = (a < 32'h0010_0000);
    bit st = (op == SW) || (op == SB);
    bit ld = (op == LW) || (op == LB) || (op == LBU);
    string tag;
    logic [31:0] eld;
    if (!backed && (st || ld)) tag = "R7";
    else case (op)
      SW: tag = "R2"; SB: tag = "R3"; LW: tag = "R4";
      LB: tag = "R5"; LBU: tag = "R6"; default: tag = "R8";
    endcase
    @(negedge clk);
    acc_op = op; acc_addr = a; acc_wdata = d;
    eld = exp_load(op, a);
    #1;
    chk(tag, "ram_wr", {31'h0, ram_wr}, {31'h0, st && backed});
    chk(tag, "ram_rd", {31'h0, ram_rd}, {31'h0, ld && backed});
    chk(tag, "lane_en", {28'h0, ram_lane_en},
        !(st && backed) ? 32'h0 : (op == SW) ? 32'hF : (32'h1 << a[1:0]));
    if (st && backed)
      chk(tag, "wdata", ram_wdata, (op == SW) ? d : {4{d[7:0]}});
    if ((st || ld) && backed)
      chk("R1", "word_addr", {14'h0, ram_word_addr}, {14'h0, a[19:2]});
    @(posedge clk); #1;
    if (st && backed) begin
      if (op == SW) for (int k = 0; k < 4; k++) shadow[{a[31:2], 2'b00} + k] = d[8*k +: 8];
      else shadow[a] = d[7:0];
    end
    chk(tag, "ld_data", ld_data, eld);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4410));
    repeat (3) @(posedge clk);
    #1 chk("R9", "ld_data in reset", ld_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R9", "ld_data after reset", ld_data, 32'h0);

    do_op(SW, 32'h0000_0000, 32'h8122_33F4);
    do_op(LB, 32'h0000_0000, 0);
    do_op(LB, 32'h0000_0003, 0);
    do_op(LBU, 32'h0000_0003, 0);
    do_op(LBU, 32'h0000_0001, 0);
    do_op(SB, 32'h0000_0023, 32'hDEAD_BEA5);
    do_op(LW, 32'h0000_0021, 0);
    do_op(SB, 32'h0000_0020, 32'h0000_0011);
    do_op(LW, 32'h0000_0022, 0);
    do_op(SW, 32'h000F_FFFC, 32'hCAFE_F00D);
    do_op(LW, 32'h000F_FFFC, 0);
    do_op(LB, 32'h000F_FFFF, 0);
    do_op(SW, 32'h0010_0000, 32'h5555_AAAA);
    do_op(SB, 32'h0010_0001, 32'h0000_0077);
    do_op(LW, 32'h0010_0000, 0);
    do_op(LW, 32'h0000_0000, 0);
    do_op(LB, 32'hFFFF_FFFF, 0);
    do_op(ADDI, 32'h0000_0000, 32'h1234_5678);
    do_op(LW, 32'h0000_0000, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      logic [31:0] a;
      int unsigned r = $urandom_range(0, 11);
      op = (r < 3) ? SW : (r < 5) ? SB : (r < 7) ? LW : (r < 9) ? LB : (r < 10) ? LBU : ADDI;
      a = ($urandom_range(0, 9) == 0) ? (32'h000F_FFC0 + $urandom_range(0, 127))
                                      : {24'h0, 8'($urandom_range(0, 63))};
      if (op == SW || op == LW) a[1:0] = 2'($urandom_range(0, 3));
      do_op(op, a, $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule